// File: doc/BRIEF.md
# Hysteretic Noise Level Classifier

This block estimates how noisy incoming video is, once per frame. It measures a single line inside vertical blanking. The chosen line is either the first or the second line that starts after the end-of-valid-data pulse. The block accumulates the absolute pixel differences supplied by an upstream difference stage over that line. It normalises the sum by a power-of-two sample count to form a 7-bit frame noise value and tracks the largest single difference as a 5-bit maximum.

On each frame strobe with detection enabled, the frame value enters an 8-deep sliding window. The reported average is then either the window mean or the current frame value alone. Two hysteretic status flags compare that average against two thresholds. The low threshold marks that noise is present and the high threshold marks medium or high noise. A flag sets when the average is above its threshold and releases only once the average drops to 3/4 or 7/8 of the threshold. A persistence flag for blanking noise needs four consecutive frames above the low threshold. A combinational stage derives a 6-bit convergence threshold from a base value and the captured maximum, for use by a downstream filter in automatic mode.

The measurement sequencer has four states. ARMED waits for the valid-end pulse. SEEK counts line strobes up to the selected line. SAMPLE accumulates pixels until the next line strobe. PARKED waits for the frame strobe. The transitions are ARMED to SEEK on the valid-end pulse, SEEK to SAMPLE on the line strobe that starts the selected line, and SAMPLE to PARKED on the next line strobe. From any state, the frame strobe returns the sequencer to ARMED and clears the accumulators.

Top module: `noise_level_classifier`

## Requirements
- R1: After reset, noise_avg, noise_max, flag_lo, flag_hi and blank_flag are all zero.
- R2: With line_sel=0 the measured line is the one opened by the first line_stb after vend_stb; with line_sel=1 it is the one opened by the second line_stb; the measured line ends at the next line_stb.
- R3: The frame value is the sum of pix_diff over pixels with pix_en=1 in the measured line, shifted right by 3, saturated at 127; noise_max becomes the largest such pix_diff, saturated at 31.
- R4: With avg_single=1, noise_avg after an enabled frame_tick equals that frame's value; with avg_single=0 it equals floor(sum of the last 8 enabled-frame values / 8), counting zeros for slots not yet filled since reset.
- R5: On an enabled frame_tick, flag_lo (flag_hi) sets when the new average is greater than thr_lo (thr_hi).
- R6: A set flag clears only when the new average is at most floor(thr*3/4) with hyst_sel=0 or floor(thr*7/8) with hyst_sel=1; between that level and the threshold it holds.
- R7: blank_flag sets on the 4th consecutive enabled frame whose average exceeds thr_lo, and clears on the first enabled frame whose average does not.
- R8: When det_en=0, frame_tick changes none of the outputs and does not advance the averaging window.
- R9: conv_level by conv_mode: 0 gives conv_base; 1 gives min(conv_base+noise_max, 63); 2 gives the smaller of min(3*noise_max, 63) and conv_base; 3 gives the larger of those two.
- R10: Pixels arriving before vend_stb, on unselected lines, on the line_stb cycle or after the measured line ends do not contribute to the frame value or maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vend_stb | input | 1 | One-cycle pulse at the end of valid picture data |
| line_stb | input | 1 | One-cycle pulse at the start of each line |
| pix_en | input | 1 | Qualifies pix_diff as a sample |
| pix_diff | input | 8 | Absolute pixel difference |
| frame_tick | input | 1 | One-cycle frame strobe; evaluation point |
| line_sel | input | 1 | 0: first line after valid end, 1: second |
| det_en | input | 1 | 1: update on frame_tick, 0: hold |
| avg_single | input | 1 | 1: single-frame value, 0: 8-frame mean |
| hyst_sel | input | 1 | Release coefficient, 0: 3/4, 1: 7/8 |
| thr_lo | input | 7 | Threshold for noise-present flag |
| thr_hi | input | 7 | Threshold for medium/high flag |
| conv_base | input | 6 | Base convergence threshold |
| conv_mode | input | 2 | Convergence derivation select |
| noise_avg | output | 7 | Reported average noise value |
| noise_max | output | 5 | Largest difference on the last measured line |
| flag_lo | output | 1 | Noise-present status |
| flag_hi | output | 1 | Medium/high noise status |
| blank_flag | output | 1 | Persistent blanking-noise flag |
| conv_level | output | 6 | Derived convergence threshold |

## Verification
The hardest case to reach is the hold band of the hysteresis. An average that lies strictly between the release level and the threshold must keep a flag set, and it must keep it set only after a preceding frame has set it. The bench runs frame sequences that first push the average over a threshold and then land it inside the band under each coefficient, before dropping it to exactly the release level. The same runs keep the average above the low threshold for exactly four frames and then fall below it, to catch the persistence flag one frame early or late. Every frame also carries decoy pixels outside the measured line, so that a wrong line count shows up in the average.

// File: rtl/nlc_pkg.sv
package nlc_pkg;

    typedef enum logic [1:0] {
        MS_ARMED  = 2'd0,
        MS_SEEK   = 2'd1,
        MS_SAMPLE = 2'd2,
        MS_PARKED = 2'd3
    } meas_state_t;

    typedef enum logic [1:0] {
        CV_FIXED = 2'd0,
        CV_SUM   = 2'd1,
        CV_MIN3  = 2'd2,
        CV_MAX3  = 2'd3
    } conv_mode_t;

endpackage

// File: rtl/nlc_line_meas.sv
module nlc_line_meas
    import nlc_pkg::*;
#(
    parameter int DIFF_W   = 8,
    parameter int PIX_LOG2 = 10,
    parameter int SHIFT    = 3,
    parameter int VAL_W    = 7,
    parameter int MAX_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vend_stb,
    input  logic              line_stb,
    input  logic              pix_en,
    input  logic [DIFF_W-1:0] pix_diff,
    input  logic              frame_tick,
    input  logic              line_sel,
    output logic [VAL_W-1:0]  frame_val,
    output logic [MAX_W-1:0]  frame_max
);

    localparam int SUM_W = DIFF_W + PIX_LOG2 + 1;

    meas_state_t       st_q, st_d;
    logic [1:0]        ln_q, ln_d;
    logic [1:0]        target;
    logic [SUM_W-1:0]  acc_q;
    logic [DIFF_W-1:0] pk_q;
    logic [SUM_W:0]    acc_wide;
    logic [SUM_W-1:0]  acc_nx;
    logic [SUM_W-1:0]  acc_sh;
    logic              take;

    assign target = line_sel ? 2'd2 : 2'd1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= MS_ARMED;
            ln_q <= '0;
        end else begin
            st_q <= st_d;
            ln_q <= ln_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        ln_d = ln_q;
        if (frame_tick) begin
            st_d = MS_ARMED;
            ln_d = '0;
        end else begin
            unique case (st_q)
                MS_ARMED: begin
                    if (vend_stb) begin
                        st_d = MS_SEEK;
                        ln_d = '0;
                    end
                end
                MS_SEEK: begin
                    if (line_stb) begin
                        ln_d = ln_q + 2'd1;
                        if (ln_q + 2'd1 == target) st_d = MS_SAMPLE;
                    end
                end
                MS_SAMPLE: begin
                    if (line_stb) st_d = MS_PARKED;
                end
                MS_PARKED: begin
                    st_d = MS_PARKED;
                end
                default: st_d = MS_ARMED;
            endcase
        end
    end

    // outputs: accumulation over the measured line
    assign take     = (st_q == MS_SAMPLE) && pix_en && !line_stb && !frame_tick;
    assign acc_wide = {1'b0, acc_q} + {{(SUM_W + 1 - DIFF_W){1'b0}}, pix_diff};
    assign acc_nx   = acc_wide[SUM_W] ? {SUM_W{1'b1}} : acc_wide[SUM_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            pk_q  <= '0;
        end else if (frame_tick) begin
            acc_q <= '0;
            pk_q  <= '0;
        end else if (take) begin
            acc_q <= acc_nx;
            if (pix_diff > pk_q) pk_q <= pix_diff;
        end
    end

    assign acc_sh    = acc_q >> SHIFT;
    assign frame_val = (|acc_sh[SUM_W-1:VAL_W]) ? {VAL_W{1'b1}} : acc_sh[VAL_W-1:0];
    assign frame_max = (|pk_q[DIFF_W-1:MAX_W]) ? {MAX_W{1'b1}} : pk_q[MAX_W-1:0];

    // R10: accumulator moves only while a line is being sampled
    a_r10_acc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != MS_SAMPLE && !frame_tick) |=> $stable(acc_q));

    // R2: sampling is entered only from the line-seeking state
    a_r2_enter_from_seek: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MS_SAMPLE && $past(st_q) != MS_SAMPLE) |-> $past(st_q) == MS_SEEK);

endmodule

// File: rtl/nlc_avg_win.sv
module nlc_avg_win #(
    parameter int VAL_W    = 7,
    parameter int WIN_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             single,
    input  logic [VAL_W-1:0] in_val,
    output logic [VAL_W-1:0] avg_nxt,
    output logic [VAL_W-1:0] avg_q
);

    localparam int DEPTH = 1 << WIN_LOG2;
    localparam int SUM_W = VAL_W + WIN_LOG2;

    logic [VAL_W-1:0] slot_q [DEPTH];
    logic [SUM_W-1:0] sum_q, sum_d;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            if (i == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)    slot_q[i] <= '0;
                    else if (push) slot_q[i] <= in_val;
                end
            end else begin : g_tail
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)    slot_q[i] <= '0;
                    else if (push) slot_q[i] <= slot_q[i-1];
                end
            end
        end
    endgenerate

    assign sum_d = sum_q - {{WIN_LOG2{1'b0}}, slot_q[DEPTH-1]}
                         + {{WIN_LOG2{1'b0}}, in_val};
    assign avg_nxt = single ? in_val : sum_d[SUM_W-1:WIN_LOG2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            avg_q <= '0;
        end else if (push) begin
            sum_q <= sum_d;
            avg_q <= avg_nxt;
        end
    end

    // R8: no update without an enabled frame
    a_r8_avg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> $stable(avg_q));

    // R4: single-frame mode reports the frame just measured
    a_r4_single_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && single) |=> avg_q == $past(in_val));

endmodule

// File: rtl/nlc_hyst_flag.sv
module nlc_hyst_flag #(
    parameter int VAL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic             hyst_sel,
    input  logic [VAL_W-1:0] val,
    input  logic [VAL_W-1:0] thr,
    output logic             flag
);

    localparam int EXT_W = VAL_W + 3;

    logic [EXT_W-1:0] thr_e, t3, t7, rel, val_e;
    logic             above, calm;

    assign thr_e = {3'b000, thr};
    assign val_e = {3'b000, val};
    assign t3    = (thr_e << 1) + thr_e;
    assign t7    = (thr_e << 3) - thr_e;
    assign rel   = hyst_sel ? (t7 >> 3) : (t3 >> 2);
    assign above = val > thr;
    assign calm  = val_e <= rel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (upd) begin
            if (above)     flag <= 1'b1;
            else if (calm) flag <= 1'b0;
        end
    end

endmodule

// File: rtl/nlc_persist_flag.sv
module nlc_persist_flag #(
    parameter int VAL_W   = 7,
    parameter int PERSIST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [VAL_W-1:0] val,
    input  logic [VAL_W-1:0] thr,
    output logic             flag
);

    localparam int CW = $clog2(PERSIST + 1);
    localparam logic [CW-1:0] FULL = CW'(PERSIST);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           run_q <= '0;
        else if (upd) begin
            if (val > thr)    run_q <= (run_q == FULL) ? run_q : run_q + 1'b1;
            else              run_q <= '0;
        end
    end

    assign flag = (run_q == FULL);

    // R7: the counter never passes the persistence limit
    a_r7_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= FULL);

endmodule

// File: rtl/nlc_conv.sv
module nlc_conv
    import nlc_pkg::*;
#(
    parameter int MAX_W  = 5,
    parameter int CONV_W = 6
) (
    input  logic [1:0]        mode,
    input  logic [CONV_W-1:0] base,
    input  logic [MAX_W-1:0]  nmax,
    output logic [CONV_W-1:0] level
);

    localparam int EW = CONV_W + MAX_W + 2;
    localparam logic [EW-1:0] CAP = EW'((1 << CONV_W) - 1);

    conv_mode_t       mode_e;
    logic [EW-1:0]    base_e, max_e, sum_e, tri_e;
    logic [CONV_W-1:0] sum_c, tri_c, lo_c, hi_c;

    assign mode_e = conv_mode_t'(mode);
    assign base_e = EW'(base);
    assign max_e  = EW'(nmax);
    assign sum_e  = base_e + max_e;
    assign tri_e  = (max_e << 1) + max_e;
    assign sum_c  = (sum_e > CAP) ? CAP[CONV_W-1:0] : sum_e[CONV_W-1:0];
    assign tri_c  = (tri_e > CAP) ? CAP[CONV_W-1:0] : tri_e[CONV_W-1:0];
    assign lo_c   = (tri_c < base) ? tri_c : base;
    assign hi_c   = (tri_c > base) ? tri_c : base;

    always_comb begin
        unique case (mode_e)
            CV_FIXED: level = base;
            CV_SUM:   level = sum_c;
            CV_MIN3:  level = lo_c;
            CV_MAX3:  level = hi_c;
            default:  level = base;
        endcase
    end

endmodule

// File: rtl/noise_level_classifier.sv
module noise_level_classifier #(
    parameter int DIFF_W   = 8,
    parameter int PIX_LOG2 = 10,
    parameter int SHIFT    = 3,
    parameter int VAL_W    = 7,
    parameter int MAX_W    = 5,
    parameter int WIN_LOG2 = 3,
    parameter int PERSIST  = 4,
    parameter int CONV_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vend_stb,
    input  logic              line_stb,
    input  logic              pix_en,
    input  logic [DIFF_W-1:0] pix_diff,
    input  logic              frame_tick,
    input  logic              line_sel,
    input  logic              det_en,
    input  logic              avg_single,
    input  logic              hyst_sel,
    input  logic [VAL_W-1:0]  thr_lo,
    input  logic [VAL_W-1:0]  thr_hi,
    input  logic [CONV_W-1:0] conv_base,
    input  logic [1:0]        conv_mode,
    output logic [VAL_W-1:0]  noise_avg,
    output logic [MAX_W-1:0]  noise_max,
    output logic              flag_lo,
    output logic              flag_hi,
    output logic              blank_flag,
    output logic [CONV_W-1:0] conv_level
);

    logic             upd;
    logic [VAL_W-1:0] frame_val, avg_nxt;
    logic [MAX_W-1:0] frame_max;

    assign upd = frame_tick && det_en;

    nlc_line_meas #(
        .DIFF_W(DIFF_W), .PIX_LOG2(PIX_LOG2), .SHIFT(SHIFT),
        .VAL_W(VAL_W), .MAX_W(MAX_W)
    ) u_meas (
        .clk(clk), .rst_n(rst_n), .vend_stb(vend_stb), .line_stb(line_stb),
        .pix_en(pix_en), .pix_diff(pix_diff), .frame_tick(frame_tick),
        .line_sel(line_sel), .frame_val(frame_val), .frame_max(frame_max)
    );

    nlc_avg_win #(.VAL_W(VAL_W), .WIN_LOG2(WIN_LOG2)) u_win (
        .clk(clk), .rst_n(rst_n), .push(upd), .single(avg_single),
        .in_val(frame_val), .avg_nxt(avg_nxt), .avg_q(noise_avg)
    );

    nlc_hyst_flag #(.VAL_W(VAL_W)) u_flag_lo (
        .clk(clk), .rst_n(rst_n), .upd(upd), .hyst_sel(hyst_sel),
        .val(avg_nxt), .thr(thr_lo), .flag(flag_lo)
    );

    nlc_hyst_flag #(.VAL_W(VAL_W)) u_flag_hi (
        .clk(clk), .rst_n(rst_n), .upd(upd), .hyst_sel(hyst_sel),
        .val(avg_nxt), .thr(thr_hi), .flag(flag_hi)
    );

    nlc_persist_flag #(.VAL_W(VAL_W), .PERSIST(PERSIST)) u_blank (
        .clk(clk), .rst_n(rst_n), .upd(upd),
        .val(avg_nxt), .thr(thr_lo), .flag(blank_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   noise_max <= '0;
        else if (upd) noise_max <= frame_max;
    end

    nlc_conv #(.MAX_W(MAX_W), .CONV_W(CONV_W)) u_conv (
        .mode(conv_mode), .base(conv_base), .nmax(noise_max), .level(conv_level)
    );

    // R1: state leaving reset is all clear
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (noise_avg == '0 && noise_max == '0 &&
                          !flag_lo && !flag_hi && !blank_flag));

    // R8: nothing moves without an enabled frame strobe
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_tick && det_en) |=> ($stable(flag_lo) && $stable(flag_hi) &&
                                     $stable(blank_flag) && $stable(noise_max)));

    // R5: a flag only rises with the average over its threshold
    a_r5_rise_lo: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_lo) |-> noise_avg > $past(thr_lo));
    a_r5_rise_hi: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_hi) |-> noise_avg > $past(thr_hi));

    // R6: a flag only falls with the average at or below its threshold
    a_r6_fall_lo: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_lo) |-> noise_avg <= $past(thr_lo));
    a_r6_fall_hi: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_hi) |-> noise_avg <= $past(thr_hi));

    // R7: persistent blanking noise implies noise present
    a_r7_blank_implies_lo: assert property (@(posedge clk) disable iff (!rst_n)
        blank_flag |-> flag_lo);

    // R9: ordering of the derived convergence level against its base
    a_r9_sum_not_below: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_mode == 2'd1) |-> conv_level >= conv_base);
    a_r9_min_not_above: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_mode == 2'd2) |-> conv_level <= conv_base);
    a_r9_max_not_below: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_mode == 2'd3) |-> conv_level >= conv_base);

endmodule

// File: tb/noise_level_classifier_bench.sv
module noise_level_classifier_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;
    localparam int THR_LO = 20;
    localparam int THR_HI = 60;

    // {d[8], n[6], pk[8], sel, single, hyst, en}
    localparam logic [25:0] VEC [NVEC] = '{
        {8'd30,  6'd8,  8'd0,  1'b0, 1'b1, 1'b0, 1'b1},
        {8'd40,  6'd8,  8'd0,  1'b1, 1'b1, 1'b0, 1'b1},
        {8'd18,  6'd8,  8'd0,  1'b0, 1'b1, 1'b0, 1'b1},
        {8'd70,  6'd8,  8'd9,  1'b1, 1'b1, 1'b0, 1'b1},
        {8'd50,  6'd8,  8'd0,  1'b0, 1'b1, 1'b0, 1'b1},
        {8'd50,  6'd8,  8'd0,  1'b1, 1'b1, 1'b1, 1'b1},
        {8'd25,  6'd8,  8'd0,  1'b0, 1'b1, 1'b1, 1'b1},
        {8'd16,  6'd8,  8'd0,  1'b1, 1'b1, 1'b1, 1'b1},
        {8'd255, 6'd40, 8'd3,  1'b0, 1'b1, 1'b0, 1'b1},
        {8'd8,   6'd8,  8'd0,  1'b1, 1'b0, 1'b0, 1'b1},
        {8'd0,   6'd8,  8'd0,  1'b0, 1'b0, 1'b0, 1'b1},
        {8'd100, 6'd8,  8'd0,  1'b0, 1'b0, 1'b0, 1'b0},
        {8'd0,   6'd8,  8'd0,  1'b1, 1'b0, 1'b1, 1'b1},
        {8'd40,  6'd12, 8'd5,  1'b0, 1'b0, 1'b0, 1'b1},
        {8'd7,   6'd8,  8'd0,  1'b1, 1'b1, 1'b0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vend_stb = 1'b0, line_stb = 1'b0, pix_en = 1'b0;
    logic [7:0] pix_diff = '0;
    logic       frame_tick = 1'b0, line_sel = 1'b0, det_en = 1'b1;
    logic       avg_single = 1'b1, hyst_sel = 1'b0;
    logic [6:0] thr_lo = 7'(THR_LO), thr_hi = 7'(THR_HI);
    logic [5:0] conv_base = '0;
    logic [1:0] conv_mode = '0;
    logic [6:0] noise_avg;
    logic [4:0] noise_max;
    logic       flag_lo, flag_hi, blank_flag;
    logic [5:0] conv_level;

    int n_chk = 0;
    int n_err = 0;

    // reference model state
    int m_win [8];
    int m_avg = 0, m_max = 0, m_lo = 0, m_hi = 0, m_run = 0;

    noise_level_classifier u_noise_level_classifier (
        .clk(clk), .rst_n(rst_n), .vend_stb(vend_stb), .line_stb(line_stb),
        .pix_en(pix_en), .pix_diff(pix_diff), .frame_tick(frame_tick),
        .line_sel(line_sel), .det_en(det_en), .avg_single(avg_single),
        .hyst_sel(hyst_sel), .thr_lo(thr_lo), .thr_hi(thr_hi),
        .conv_base(conv_base), .conv_mode(conv_mode), .noise_avg(noise_avg),
        .noise_max(noise_max), .flag_lo(flag_lo), .flag_hi(flag_hi),
        .blank_flag(blank_flag), .conv_level(conv_level)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pixel(input int v);
        @(negedge clk);
        pix_en   = 1'b1;
        pix_diff = 8'(v);
        @(negedge clk);
        pix_en   = 1'b0;
    endtask

    task automatic pulse_vend();
        @(negedge clk); vend_stb = 1'b1;
        @(negedge clk); vend_stb = 1'b0;
    endtask

    task automatic pulse_line();
        @(negedge clk); line_stb = 1'b1;
        @(negedge clk); line_stb = 1'b0;
    endtask

    task automatic pulse_frame();
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0;
    endtask

    // R2 R10: decoy pixels sit everywhere except the selected line
    task automatic run_frame(input int d, input int n, input int pk, input int sel);
        line_sel = sel[0];
        pixel(200);
        pixel(200);
        pulse_vend();
        pixel(200);
        for (int ln = 1; ln <= 3; ln++) begin
            pulse_line();
            if (ln == sel + 1) begin
                for (int k = 0; k < n; k++) pixel(d);
                pixel(pk);
            end else begin
                for (int k = 0; k < 3; k++) pixel(200);
            end
        end
        pixel(200);
        pulse_frame();
    endtask

    task automatic model_frame(input int d, input int n, input int pk,
                               input int single, input int hyst, input int en);
        int fv, mx, s, rl, rh;
        if (en == 0) return;
        fv = (n * d + pk) >> 3;
        if (fv > 127) fv = 127;
        mx = (pk > d) ? pk : d;
        if (mx > 31) mx = 31;
        for (int i = 7; i > 0; i--) m_win[i] = m_win[i-1];
        m_win[0] = fv;
        s = 0;
        for (int i = 0; i < 8; i++) s += m_win[i];
        m_avg = single ? fv : s / 8;
        m_max = mx;
        rl = hyst ? (THR_LO * 7) / 8 : (THR_LO * 3) / 4;
        rh = hyst ? (THR_HI * 7) / 8 : (THR_HI * 3) / 4;
        if (m_avg > THR_LO) m_lo = 1; else if (m_avg <= rl) m_lo = 0;
        if (m_avg > THR_HI) m_hi = 1; else if (m_avg <= rh) m_hi = 0;
        if (m_avg > THR_LO) m_run = (m_run < 4) ? m_run + 1 : 4; else m_run = 0;
    endtask

    function automatic int conv_ref(input int mode, input int base, input int mx);
        int t, sm;
        t  = (3 * mx > 63) ? 63 : 3 * mx;
        sm = (base + mx > 63) ? 63 : base + mx;
        case (mode)
            0: return base;
            1: return sm;
            2: return (t < base) ? t : base;
            default: return (t > base) ? t : base;
        endcase
    endfunction

    task automatic check_reset_state(input string tag);
        chk({tag, " R1 noise_avg"}, int'(noise_avg), 0);
        chk({tag, " R1 noise_max"}, int'(noise_max), 0);
        chk({tag, " R1 flag_lo"}, int'(flag_lo), 0);
        chk({tag, " R1 flag_hi"}, int'(flag_hi), 0);
        chk({tag, " R1 blank_flag"}, int'(blank_flag), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_win[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("post-reset");

        // vector table walk
        for (int v = 0; v < NVEC; v++) begin
            int d, n, pk, sel, single, hyst, en;
            string pre;
            d      = int'(VEC[v][25:18]);
            n      = int'(VEC[v][17:12]);
            pk     = int'(VEC[v][11:4]);
            sel    = int'(VEC[v][3]);
            single = int'(VEC[v][2]);
            hyst   = int'(VEC[v][1]);
            en     = int'(VEC[v][0]);
            avg_single = single[0];
            hyst_sel   = hyst[0];
            det_en     = en[0];
            run_frame(d, n, pk, sel);
            model_frame(d, n, pk, single, hyst, en);
            @(negedge clk);
            pre = $sformatf("vec%0d", v);
            chk({pre, en ? " R2 R3 R4 R10 noise_avg" : " R8 noise_avg hold"},
                int'(noise_avg), m_avg);
            chk({pre, en ? " R3 noise_max" : " R8 noise_max hold"},
                int'(noise_max), m_max);
            chk({pre, " R5 R6 flag_lo"}, int'(flag_lo), m_lo);
            chk({pre, " R5 R6 flag_hi"}, int'(flag_hi), m_hi);
            chk({pre, " R7 blank_flag"}, int'(blank_flag), (m_run == 4) ? 1 : 0);
        end

        // R9: convergence derivation, last max is 7
        for (int b = 0; b < 3; b++) begin
            int base;
            base = (b == 0) ? 10 : ((b == 1) ? 30 : 60);
            for (int md = 0; md < 4; md++) begin
                conv_base = 6'(base);
                conv_mode = 2'(md);
                @(negedge clk);
                chk($sformatf("R9 conv_level mode=%0d base=%0d", md, base),
                    int'(conv_level), conv_ref(md, base, m_max));
            end
        end

        // R9: saturated maximum drives the 63 cap
        det_en = 1'b1;
        avg_single = 1'b1;
        run_frame(255, 8, 0, 0);
        model_frame(255, 8, 0, 1, 0, 1);
        @(negedge clk);
        conv_base = 6'd50;
        conv_mode = 2'd1;
        @(negedge clk);
        chk("R9 conv_level cap sum", int'(conv_level), 63);
        conv_mode = 2'd3;
        @(negedge clk);
        chk("R9 conv_level cap triple", int'(conv_level), 63);

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("mid-run");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule